// File: doc/BRIEF.md
# SPI FIFO Request Controller

This block sits between a bus slave and the shift engine of a full-duplex serial peripheral. It holds two independent 64-byte queues. The transmit queue is filled from bus writes and emptied one byte at a time by the shifter. The receive queue is filled one byte at a time by the shifter and emptied by bus reads. Because the queues are separate, data can move in both directions in the same cycle.

Each bus access moves one, two or four bytes, chosen by a size input that applies to the current access. A write splits its data word into bytes, least significant byte first. A read packs the oldest bytes into the low end of the returned word. The fill level of each queue is compared with a programmable trigger level to drive an interrupt line. Separate enables turn on a DMA request for each queue. Each request works in single-unit mode or in 4-unit burst mode. A write that does not fit and a read that finds too few bytes are both dropped, and each sets a sticky error flag that only reset clears.

Top module: `spi_fifo_req_ctrl`

## Requirements
- R1: After reset, both fill levels are 0, `tx_empty` is 1, both sticky flags are 0 and `bus_rdata` is 0.
- R2: An accepted write stores its unit bytes in the TX queue with bits 7:0 first. `tx_level` rises by the unit size at the next clock. `tx_byte` always shows the oldest stored byte. `tx_pop` on a non-empty queue removes exactly one byte.
- R3: A write for which the free space (64 minus `tx_level`) is smaller than the unit size stores nothing and sets `tx_ovr`. `tx_ovr` stays at 1 until reset.
- R4: While `bus_rd` is high and `rx_level` is at least the unit size, `bus_rdata` returns the oldest unit bytes in the same cycle. The oldest byte is in bits 7:0 and the unused upper bits are 0. `rx_level` falls by the unit size at the next clock.
- R5: A read with `rx_level` below the unit size returns 0, removes nothing and sets `rx_udr`. `rx_udr` stays at 1 until reset.
- R6: An `rx_push` while `rx_level` is 64 is discarded. A `tx_pop` while `tx_empty` is 1 has no effect.
- R7: The `acc_size` encoding is 0 = 1 byte, 1 = 2 bytes, and 2 or 3 = 4 bytes.
- R8: `tx_irq` is 1 exactly when `tx_level` <= `tx_trig`. `rx_irq` is 1 exactly when `rx_level` >= `rx_trig`.
- R9: With `dma_burst` = 0, `tx_dma_req` = `tx_dma_on` and (free space >= unit size), and `rx_dma_req` = `rx_dma_on` and (`rx_level` >= unit size). At 1-byte units this means TX requests until the queue is full and RX requests while it is not empty.
- R10: With `dma_burst` = 1, the same rules apply with four times the unit size in place of the unit size.
- R11: A bus access and a shifter access to the same queue in one cycle both take effect. Acceptance of each is judged on the level before that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_size | input | 2 | Unit size of the current bus access |
| bus_wr | input | 1 | Write to the TX data register |
| bus_wdata | input | 32 | Write data, first byte in bits 7:0 |
| bus_rd | input | 1 | Read from the RX data register |
| bus_rdata | output | 32 | Read data, valid in the read cycle |
| tx_pop | input | 1 | Shifter takes one TX byte |
| tx_byte | output | 8 | Oldest TX byte |
| tx_empty | output | 1 | TX queue is empty |
| rx_push | input | 1 | Shifter delivers one RX byte |
| rx_byte | input | 8 | Received byte |
| tx_trig | input | 7 | TX interrupt trigger level |
| rx_trig | input | 7 | RX interrupt trigger level |
| tx_dma_on | input | 1 | Enable the TX DMA request |
| rx_dma_on | input | 1 | Enable the RX DMA request |
| dma_burst | input | 1 | 1 selects 4-unit burst requests |
| tx_level | output | 7 | TX fill level, 0 to 64 |
| rx_level | output | 7 | RX fill level, 0 to 64 |
| tx_irq | output | 1 | TX interrupt |
| rx_irq | output | 1 | RX interrupt |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |
| tx_ovr | output | 1 | Sticky flag for a dropped write |
| rx_udr | output | 1 | Sticky flag for a dropped read |

## Verification
The bench fills the TX queue to exactly 64 bytes and then tries one more write. A design that stored part of that write, or wrapped its pointers, would show a level above 64 or corrupted bytes at `tx_byte`. Reads are made with the size larger than the stored byte count, to catch a design that pops anyway or returns stale bytes. A push into a full RX queue and a pop from an empty TX queue are both applied, and either one would corrupt the level if it were accepted. A long mixed phase runs bus and shifter traffic on the same queue in the same cycle while the trigger levels and DMA modes change. An off-by-one in a trigger comparison, or a burst request raised one unit too early, would then show as a mismatch against the reference model.

// File: rtl/spi_frq_pkg.sv
package spi_frq_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } acc_size_e;

    // Number of bytes moved by one bus access of the given size
    function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
        case (acc_size_e'(sz))
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/spi_frq_fifo.sv
// Byte queue that accepts and releases up to MAXB bytes per cycle.
// DEPTH must be a power of two. The caller never overfills or overdrains it.
module spi_frq_fifo #(
    parameter  int DEPTH = 64,
    parameter  int MAXB  = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int NW    = $clog2(MAXB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NW-1:0]     push_n,
    input  logic [8*MAXB-1:0] push_data,
    input  logic [NW-1:0]     pop_n,
    output logic [8*MAXB-1:0] head,
    output logic [CW-1:0]     count
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t s_d, s_q;
    logic [7:0] mem [DEPTH];

    always_comb begin
        s_d      = s_q;
        s_d.wptr = s_q.wptr + AW'(push_n);
        s_d.rptr = s_q.rptr + AW'(pop_n);
        s_d.cnt  = s_q.cnt + CW'(push_n) - CW'(pop_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < MAXB; i++) begin
            if (NW'(i) < push_n) mem[s_q.wptr + AW'(i)] <= push_data[8*i +: 8];
        end
    end

    for (genvar g = 0; g < MAXB; g++) begin : g_head
        assign head[8*g +: 8] = mem[s_q.rptr + AW'(g)];
    end

    assign count = s_q.cnt;

endmodule

// File: rtl/spi_frq_req.sv
// Interrupt and DMA request decisions from the registered fill levels.
module spi_frq_req #(
    parameter  int DEPTH = 64,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] tx_cnt,
    input  logic [CW-1:0] rx_cnt,
    input  logic [CW-1:0] tx_trig,
    input  logic [CW-1:0] rx_trig,
    input  logic [2:0]    nb,
    input  logic          burst,
    input  logic          tx_on,
    input  logic          rx_on,
    output logic          tx_irq,
    output logic          rx_irq,
    output logic          tx_dreq,
    output logic          rx_dreq
);

    logic [CW-1:0] free, need;

    always_comb begin
        free    = CW'(DEPTH) - tx_cnt;
        need    = burst ? (CW'(nb) << 2) : CW'(nb);
        tx_irq  = tx_cnt <= tx_trig;
        rx_irq  = rx_cnt >= rx_trig;
        tx_dreq = tx_on && (free >= need);
        rx_dreq = rx_on && (rx_cnt >= need);
    end

endmodule

// File: rtl/spi_fifo_req_ctrl.sv
module spi_fifo_req_ctrl #(
    parameter  int DEPTH = 64,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    acc_size,
    input  logic          bus_wr,
    input  logic [31:0]   bus_wdata,
    input  logic          bus_rd,
    output logic [31:0]   bus_rdata,
    input  logic          tx_pop,
    output logic [7:0]    tx_byte,
    output logic          tx_empty,
    input  logic          rx_push,
    input  logic [7:0]    rx_byte,
    input  logic [LW-1:0] tx_trig,
    input  logic [LW-1:0] rx_trig,
    input  logic          tx_dma_on,
    input  logic          rx_dma_on,
    input  logic          dma_burst,
    output logic [LW-1:0] tx_level,
    output logic [LW-1:0] rx_level,
    output logic          tx_irq,
    output logic          rx_irq,
    output logic          tx_dma_req,
    output logic          rx_dma_req,
    output logic          tx_ovr,
    output logic          rx_udr
);
    import spi_frq_pkg::*;

    typedef struct packed {
        logic ovr;
        logic udr;
    } flags_t;

    flags_t f_d, f_q;

    logic [2:0]    nb;
    logic [LW-1:0] nbw, tx_free;
    logic          wr_ok, rd_ok;
    logic [2:0]    tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    logic [31:0]   tx_head, rx_head;

    always_comb begin
        nb        = unit_bytes(acc_size);
        nbw       = LW'(nb);
        tx_free   = LW'(DEPTH) - tx_level;
        wr_ok     = bus_wr && (tx_free >= nbw);
        rd_ok     = bus_rd && (rx_level >= nbw);
        tx_push_n = wr_ok ? nb : 3'd0;
        tx_pop_n  = (tx_pop && tx_level != '0) ? 3'd1 : 3'd0;
        rx_push_n = (rx_push && rx_level != LW'(DEPTH)) ? 3'd1 : 3'd0;
        rx_pop_n  = rd_ok ? nb : 3'd0;
    end

    always_comb begin
        f_d = f_q;
        if (bus_wr && !wr_ok) f_d.ovr = 1'b1;
        if (bus_rd && !rd_ok) f_d.udr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    spi_frq_fifo #(.DEPTH(DEPTH), .MAXB(4)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (tx_push_n),
        .push_data (bus_wdata),
        .pop_n     (tx_pop_n),
        .head      (tx_head),
        .count     (tx_level)
    );

    spi_frq_fifo #(.DEPTH(DEPTH), .MAXB(4)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (rx_push_n),
        .push_data ({24'd0, rx_byte}),
        .pop_n     (rx_pop_n),
        .head      (rx_head),
        .count     (rx_level)
    );

    spi_frq_req #(.DEPTH(DEPTH)) u_req (
        .tx_cnt  (tx_level),
        .rx_cnt  (rx_level),
        .tx_trig (tx_trig),
        .rx_trig (rx_trig),
        .nb      (nb),
        .burst   (dma_burst),
        .tx_on   (tx_dma_on),
        .rx_on   (rx_dma_on),
        .tx_irq  (tx_irq),
        .rx_irq  (rx_irq),
        .tx_dreq (tx_dma_req),
        .rx_dreq (rx_dma_req)
    );

    for (genvar g = 0; g < 4; g++) begin : g_rd
        assign bus_rdata[8*g +: 8] = (rd_ok && (3'(g) < nb)) ? rx_head[8*g +: 8] : 8'd0;
    end

    assign tx_byte  = tx_head[7:0];
    assign tx_empty = (tx_level == '0);
    assign tx_ovr   = f_q.ovr;
    assign rx_udr   = f_q.udr;

endmodule

// File: rtl/spi_frq_checker.sv
module spi_frq_checker #(
    parameter  int DEPTH = 64,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    acc_size,
    input logic          bus_wr,
    input logic [31:0]   bus_wdata,
    input logic          bus_rd,
    input logic [31:0]   bus_rdata,
    input logic          tx_pop,
    input logic [7:0]    tx_byte,
    input logic          tx_empty,
    input logic          rx_push,
    input logic [7:0]    rx_byte,
    input logic [LW-1:0] tx_trig,
    input logic [LW-1:0] rx_trig,
    input logic          tx_dma_on,
    input logic          rx_dma_on,
    input logic          dma_burst,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic          tx_irq,
    input logic          rx_irq,
    input logic          tx_dma_req,
    input logic          rx_dma_req,
    input logic          tx_ovr,
    input logic          rx_udr
);
    import spi_frq_pkg::*;

    int nbi;
    assign nbi = int'(unit_bytes(acc_size));

    assert_level_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tx_level) <= DEPTH && int'(rx_level) <= DEPTH);

    assert_tx_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (DEPTH - int'(tx_level)) < nbi) |=>
        (tx_ovr && int'(tx_level) == int'($past(tx_level)) - ($past(tx_pop && tx_level != 0) ? 1 : 0)));

    assert_ovr_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovr |=> tx_ovr);

    assert_rd_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(rx_level) < nbi) |-> (bus_rdata == 32'd0));

    assert_udr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_udr |=> rx_udr);

    assert_rx_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && int'(rx_level) == DEPTH && !bus_rd) |=> int'(rx_level) == DEPTH);

    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && tx_pop && !bus_wr) |=> tx_empty);

    assert_dma_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_dma_on |-> !tx_dma_req) and (!rx_dma_on |-> !rx_dma_req));

    assert_burst_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_burst && rx_dma_req) |-> int'(rx_level) >= 4 * nbi);

endmodule

bind spi_fifo_req_ctrl spi_frq_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_spi_fifo_req_ctrl.sv
module sim_spi_fifo_req_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [1:0]  sz = 2'd0;
    logic        wr = 1'b0, rd = 1'b0, tpop = 1'b0, rpush = 1'b0;
    logic [31:0] wdata = 32'd0;
    logic [7:0]  rbyte = 8'd0;
    logic [6:0]  ttrig = 7'd8, rtrig = 7'd8;
    logic        tdon = 1'b0, rdon = 1'b0, burst = 1'b0;

    logic [31:0] rdata;
    logic [7:0]  txb;
    logic        txe, tirq, rirq, tdreq, rdreq, ovr, udr;
    logic [6:0]  tlev, rlev;

    spi_fifo_req_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .acc_size(sz),
        .bus_wr(wr), .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata),
        .tx_pop(tpop), .tx_byte(txb), .tx_empty(txe),
        .rx_push(rpush), .rx_byte(rbyte),
        .tx_trig(ttrig), .rx_trig(rtrig),
        .tx_dma_on(tdon), .rx_dma_on(rdon), .dma_burst(burst),
        .tx_level(tlev), .rx_level(rlev), .tx_irq(tirq), .rx_irq(rirq),
        .tx_dma_req(tdreq), .rx_dma_req(rdreq), .tx_ovr(ovr), .rx_udr(udr)
    );

    int total = 0, bad = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    bit m_ovr = 0, m_udr = 0;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int nbytes(logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    // One cycle: compare against the model, then advance the model past the edge.
    task automatic cyc();
        int n, need, ts, rs, exp_rd;
        #1;
        n = nbytes(sz);
        need = burst ? 4 * n : n;
        ts = txq.size();
        rs = rxq.size();
        chk("R2 tx_level", int'(tlev), ts);
        chk("R4 rx_level", int'(rlev), rs);
        chk("R6 tx_empty", int'(txe), (ts == 0) ? 1 : 0);
        if (ts > 0) chk("R2 tx_byte", int'(txb), int'(txq[0]));
        exp_rd = 0;
        if (rd && rs >= n) for (int i = 0; i < n; i++) exp_rd |= int'(rxq[i]) << (8 * i);
        chk((rd && rs < n) ? "R5 rdata" : "R4 rdata", int'(rdata), exp_rd);
        chk("R3 tx_ovr", int'(ovr), int'(m_ovr));
        chk("R5 rx_udr", int'(udr), int'(m_udr));
        chk("R8 tx_irq", int'(tirq), (ts <= int'(ttrig)) ? 1 : 0);
        chk("R8 rx_irq", int'(rirq), (rs >= int'(rtrig)) ? 1 : 0);
        chk(burst ? "R10 tx_dma" : "R9 tx_dma", int'(tdreq), (tdon && (64 - ts) >= need) ? 1 : 0);
        chk(burst ? "R10 rx_dma" : "R9 rx_dma", int'(rdreq), (rdon && rs >= need) ? 1 : 0);
        if (tpop && ts > 0) void'(txq.pop_front());
        if (wr) begin
            if (64 - ts >= n) for (int i = 0; i < n; i++) txq.push_back(wdata[8*i +: 8]);
            else m_ovr = 1;
        end
        if (rd) begin
            if (rs >= n) for (int i = 0; i < n; i++) void'(rxq.pop_front());
            else m_udr = 1;
        end
        if (rpush && rs < 64) rxq.push_back(rbyte);
        @(negedge clk);
    endtask

    task automatic idle();
        wr = 0; rd = 0; tpop = 0; rpush = 0;
    endtask

    bit done = 0;

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 tx_level", int'(tlev), 0);
        chk("R1 rx_level", int'(rlev), 0);
        chk("R1 tx_empty", int'(txe), 1);
        chk("R1 flags", int'({ovr, udr}), 0);
        chk("R1 rdata", int'(rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cyc();

        // R2/R7: one write of each size, then drain through the shifter
        wr = 1; sz = 2'd0; wdata = 32'hFFFF_FFA1; cyc();
        sz = 2'd1; wdata = 32'hEEEE_B3B2; cyc();
        sz = 2'd3; wdata = 32'h4433_2211; cyc();
        idle();
        chk("R7 size3 is 4 bytes", int'(tlev), 7);
        cyc();
        tpop = 1;
        repeat (8) cyc();       // last pop is on an empty queue (R6)
        idle(); cyc();

        // R3: fill TX to exactly 64, then one extra write
        wr = 1; sz = 2'd2;
        for (int i = 0; i < 16; i++) begin wdata = 32'h0101_0101 * (i + 1); cyc(); end
        sz = 2'd0; wdata = 32'h0000_00EE; cyc();
        idle(); cyc();
        chk("R3 full level held", int'(tlev), 64);
        chk("R3 ovr set", int'(ovr), 1);
        // R11: write and pop in the same cycle at full (write judged on old level)
        wr = 1; tpop = 1; sz = 2'd0; wdata = 32'h5A; cyc();
        idle(); cyc();
        chk("R11 full pop+write", int'(tlev), 63);
        tpop = 1; repeat (66) cyc(); idle(); cyc();

        // R4/R5: receive path
        for (int i = 0; i < 10; i++) begin rpush = 1; rbyte = 8'h30 + 8'(i); cyc(); end
        idle();
        rd = 1; sz = 2'd2; cyc();
        sz = 2'd1; cyc();
        sz = 2'd0; cyc();
        sz = 2'd2; cyc();       // 3 left, 4 wanted: underrun
        idle(); cyc();
        chk("R5 udr set", int'(udr), 1);
        chk("R5 no pop", int'(rlev), 3);
        // R11: read and push together
        rd = 1; rpush = 1; sz = 2'd1; rbyte = 8'h77; cyc();
        idle(); cyc();
        chk("R11 rx rd+push", int'(rlev), 2);
        // R6: fill RX beyond 64
        rpush = 1;
        for (int i = 0; i < 66; i++) begin rbyte = 8'(i); cyc(); end
        idle(); cyc();
        chk("R6 rx full drop", int'(rlev), 64);
        rd = 1; sz = 2'd2; repeat (16) cyc(); idle(); cyc();

        // Mixed traffic with changing thresholds and DMA modes (R8/R9/R10/R11)
        for (int k = 0; k < 4000; k++) begin
            if (k % 150 == 0) begin
                ttrig = 7'($urandom_range(0, 64));
                rtrig = 7'($urandom_range(0, 64));
                tdon = 1'($urandom); rdon = 1'($urandom); burst = 1'($urandom);
            end
            sz    = 2'($urandom);
            wr    = ($urandom_range(0, 9) < 3);
            wdata = $urandom;
            tpop  = ($urandom_range(0, 9) < 6);
            rpush = ($urandom_range(0, 9) < 6);
            rbyte = 8'($urandom);
            rd    = ($urandom_range(0, 9) < 3);
            cyc();
        end
        idle(); cyc();

        done = 1;
        summary();
        $finish;
    end
endmodule